// File: doc/BRIEF.md
# Serial Link Receive Synchronization Controller

This block decides whether the receive side of an 8b/10b serial link is locked. An upstream decoder hands it a strobe for each decoded byte block and a strobe for each message group, each tagged valid or invalid. The controller counts runs of same-polarity events. It climbs from an unlocked state to block lock, and then to frame lock, as runs of valid events reach programmable lengths. It falls back one level or all the way to unlocked when runs of invalid events reach their own lengths.

The current lock state drives two things. The first is a gate on the receive error stream: when suppression is enabled, errors are passed only in frame lock. The second is a request to switch off SerDes symbol alignment once frame lock is held. An optional fallback counts line-code violations while the link sits in frame lock and drops straight to unlocked when a programmed count is met. A link enable holds the machine unlocked whenever it is low.

Top module: `lnk_rx_sync`

## Requirements
- R1: While rst_n is low, and on the cycle after any cycle in which link_en_i is low, state_o reads 0 (unlocked) and both run counts are empty.
- R2: In state 0, when a valid-block strobe (blk_vld_i=1, blk_good_i=1) ends a run of consecutive valid blocks whose length reaches blk_ok_thr_i, state_o reads 1 (block lock) after that clock edge. A threshold of 0 behaves like 1.
- R3: In state 1, when a valid-group strobe (grp_vld_i=1, grp_good_i=1) ends a run of valid groups whose length reaches grp_ok_thr_i, state_o reads 3 (frame lock) after that edge.
- R4: In state 3, a run of invalid groups (grp_good_i=0) whose length reaches grp_bad_thr_i returns state_o to 1.
- R5: In state 1 or 3, a run of invalid blocks whose length reaches blk_bad_thr_i returns state_o to 0. In state 1 this takes priority over a group run completing on the same cycle.
- R6: A strobe of opposite polarity restarts the run at length 1. Every state change empties the block, group and violation counts, and the strobes of that cycle are not counted.
- R7: In state 0, invalid-block strobes leave the state at 0, whatever blk_bad_thr_i is.
- R8: err_o equals err_i when err_supp_en_i is 0. When err_supp_en_i is 1, err_o equals err_i in state 3 and is 0 in every other state.
- R9: align_dis_o is 1 exactly when auto_align_en_i is 1 and state_o is 3.
- R10: With lcv_unsync_en_i=1 in state 3, the lcv_i strobe that brings the violation count since the last state change to lcv_thr_i moves state_o to 0. With lcv_unsync_en_i=0, lcv_i has no effect.
- R11: state_o never takes the value 2 and never goes from 0 to 3 in one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_en_i | input | 1 | Run enable; low holds the machine unlocked |
| err_supp_en_i | input | 1 | Mask errors outside frame lock |
| auto_align_en_i | input | 1 | Allow the alignment-disable request |
| lcv_unsync_en_i | input | 1 | Allow violation-driven fallback from frame lock |
| blk_ok_thr_i | input | 16 | Valid-block run length for block lock |
| blk_bad_thr_i | input | 16 | Invalid-block run length for unlock |
| grp_ok_thr_i | input | 16 | Valid-group run length for frame lock |
| grp_bad_thr_i | input | 16 | Invalid-group run length for falling back to block lock |
| lcv_thr_i | input | 16 | Violation count for the fallback |
| blk_vld_i | input | 1 | Byte-block strobe |
| blk_good_i | input | 1 | Byte block decoded cleanly |
| grp_vld_i | input | 1 | Message-group strobe |
| grp_good_i | input | 1 | Message group valid |
| lcv_i | input | 1 | Line-code violation strobe |
| err_i | input | 1 | Raw receive error |
| state_o | output | 2 | Lock state: 0 unlocked, 1 block lock, 3 frame lock |
| err_o | output | 1 | Gated receive error |
| align_dis_o | output | 1 | Request to disable symbol alignment |

## Verification
The bench first goes after the run-restart rule. A design that keeps counting across an opposite-polarity strobe locks early, and one that fails to empty the counts on a state change climbs straight through the next level on stale runs. It also drives an invalid-block run and a completing group run into the same cycle in block lock, where a wrong priority lands in frame lock instead of unlocked. It checks that invalid blocks in the unlocked state are ignored, that a zero threshold acts like one, and that violations move the state only in frame lock when enabled. Random runs with short thresholds then cross every transition many times against a reference model.

// File: rtl/lnk_sync_pkg.sv
package lnk_sync_pkg;
    // State codes are visible on the port; frame lock is 3 by definition.
    typedef enum logic [1:0] {
        ST_LOST = 2'd0,
        ST_BLK  = 2'd1,
        ST_FRM  = 2'd3
    } sync_st_e;

    localparam int unsigned NUM_RUNS = 2;  // 0: byte blocks, 1: message groups
    localparam int unsigned RUN_BLK  = 0;
    localparam int unsigned RUN_GRP  = 1;
endpackage

// File: rtl/lnk_run_cnt.sv
// Tracks the length and polarity of the current run of same-kind events.
module lnk_run_cnt #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             evt_i,
    input  logic             good_i,
    input  logic [CNT_W-1:0] thr_ok_i,
    input  logic [CNT_W-1:0] thr_bad_i,
    output logic             hit_ok_o,
    output logic             hit_bad_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic             pol;
        logic [CNT_W-1:0] len;
    } run_t;

    run_t             run_d, run_q;
    logic [CNT_W-1:0] len_next;

    always_comb begin
        run_d = run_q;
        if (good_i == run_q.pol) begin
            len_next = (run_q.len == CNT_MAX) ? CNT_MAX : run_q.len + CNT_ONE;
        end else begin
            len_next = CNT_ONE;
        end
        hit_ok_o  = evt_i &  good_i & (len_next >= thr_ok_i);
        hit_bad_o = evt_i & ~good_i & (len_next >= thr_bad_i);
        if (clr_i) begin
            run_d = '0;
        end else if (evt_i) begin
            run_d.pol = good_i;
            run_d.len = len_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end
endmodule

// File: rtl/lnk_lcv_cnt.sv
// Counts line-code violations since the last clear, saturating.
module lnk_lcv_cnt #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             evt_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             hit_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_d, cnt_q, cnt_inc;

    always_comb begin
        cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_ONE;
        hit_o   = evt_i & (cnt_inc >= thr_i);
        cnt_d   = cnt_q;
        if (clr_i)      cnt_d = '0;
        else if (evt_i) cnt_d = cnt_inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/lnk_rx_sync.sv
module lnk_rx_sync
    import lnk_sync_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_en_i,
    input  logic             err_supp_en_i,
    input  logic             auto_align_en_i,
    input  logic             lcv_unsync_en_i,
    input  logic [CNT_W-1:0] blk_ok_thr_i,
    input  logic [CNT_W-1:0] blk_bad_thr_i,
    input  logic [CNT_W-1:0] grp_ok_thr_i,
    input  logic [CNT_W-1:0] grp_bad_thr_i,
    input  logic [CNT_W-1:0] lcv_thr_i,
    input  logic             blk_vld_i,
    input  logic             blk_good_i,
    input  logic             grp_vld_i,
    input  logic             grp_good_i,
    input  logic             lcv_i,
    input  logic             err_i,
    output logic [1:0]       state_o,
    output logic             err_o,
    output logic             align_dis_o
);
    typedef struct packed {
        sync_st_e st;
    } ctl_t;

    ctl_t                 ctl_d, ctl_q;
    logic                 cnt_clr;
    logic                 lcv_hit;
    logic [NUM_RUNS-1:0]  evt, good, hit_ok, hit_bad;
    logic [CNT_W-1:0]     thr_ok  [NUM_RUNS];
    logic [CNT_W-1:0]     thr_bad [NUM_RUNS];

    always_comb begin
        evt[RUN_BLK]      = blk_vld_i;
        good[RUN_BLK]     = blk_good_i;
        thr_ok[RUN_BLK]   = blk_ok_thr_i;
        thr_bad[RUN_BLK]  = blk_bad_thr_i;
        evt[RUN_GRP]      = grp_vld_i;
        good[RUN_GRP]     = grp_good_i;
        thr_ok[RUN_GRP]   = grp_ok_thr_i;
        thr_bad[RUN_GRP]  = grp_bad_thr_i;
    end

    for (genvar g = 0; g < NUM_RUNS; g++) begin : g_run
        lnk_run_cnt #(.CNT_W(CNT_W)) u_run (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_i     (cnt_clr),
            .evt_i     (evt[g]),
            .good_i    (good[g]),
            .thr_ok_i  (thr_ok[g]),
            .thr_bad_i (thr_bad[g]),
            .hit_ok_o  (hit_ok[g]),
            .hit_bad_o (hit_bad[g])
        );
    end

    lnk_lcv_cnt #(.CNT_W(CNT_W)) u_lcv (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .evt_i (lcv_i),
        .thr_i (lcv_thr_i),
        .hit_o (lcv_hit)
    );

    // Next state; unlock causes are checked before partial fallbacks.
    always_comb begin
        ctl_d = ctl_q;
        if (!link_en_i) begin
            ctl_d.st = ST_LOST;
        end else begin
            unique case (ctl_q.st)
                ST_LOST: if (hit_ok[RUN_BLK]) ctl_d.st = ST_BLK;
                ST_BLK: begin
                    if (hit_bad[RUN_BLK])     ctl_d.st = ST_LOST;
                    else if (hit_ok[RUN_GRP]) ctl_d.st = ST_FRM;
                end
                ST_FRM: begin
                    if (lcv_unsync_en_i && lcv_hit) ctl_d.st = ST_LOST;
                    else if (hit_bad[RUN_BLK])      ctl_d.st = ST_LOST;
                    else if (hit_bad[RUN_GRP])      ctl_d.st = ST_BLK;
                end
                default: ctl_d.st = ST_LOST;
            endcase
        end
        cnt_clr = !link_en_i || (ctl_d.st != ctl_q.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_LOST};
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        state_o     = ctl_q.st;
        err_o       = err_i & (~err_supp_en_i | (ctl_q.st == ST_FRM));
        align_dis_o = auto_align_en_i & (ctl_q.st == ST_FRM);
    end
endmodule

// File: rtl/lnk_rx_sync_chk.sv
module lnk_rx_sync_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       link_en_i,
    input logic       err_supp_en_i,
    input logic       auto_align_en_i,
    input logic       err_i,
    input logic [1:0] state_o,
    input logic       err_o,
    input logic       align_dis_o
);
    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !link_en_i |=> (state_o == 2'd0)); // R1

    AST_NO_CODE_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        state_o != 2'd2); // R11

    AST_NO_JUMP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0) |=> (state_o != 2'd3)); // R11

    AST_FRAME_VIA_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3 && $past(state_o) != 2'd3) |-> ($past(state_o) == 2'd1)); // R3

    AST_ERR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (err_supp_en_i && state_o != 2'd3) |-> !err_o); // R8

    AST_ERR_PASSED: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_supp_en_i && err_i) |-> err_o); // R8

    AST_ALIGN_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        align_dis_o |-> (state_o == 2'd3 && auto_align_en_i)); // R9
endmodule

bind lnk_rx_sync lnk_rx_sync_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .link_en_i       (link_en_i),
    .err_supp_en_i   (err_supp_en_i),
    .auto_align_en_i (auto_align_en_i),
    .err_i           (err_i),
    .state_o         (state_o),
    .err_o           (err_o),
    .align_dis_o     (align_dis_o)
);

// File: tb/lnk_rx_sync_tb.sv
module lnk_rx_sync_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_en_i = 0, err_supp_en_i = 0, auto_align_en_i = 0, lcv_unsync_en_i = 0;
    logic [15:0] blk_ok_thr_i = 1, blk_bad_thr_i = 1, grp_ok_thr_i = 1, grp_bad_thr_i = 1, lcv_thr_i = 1;
    logic        blk_vld_i = 0, blk_good_i = 0, grp_vld_i = 0, grp_good_i = 0, lcv_i = 0, err_i = 0;
    logic [1:0]  state_o;
    logic        err_o, align_dis_o;

    int checks = 0;
    int errors = 0;
    // reference model state
    int m_st = 0;
    int m_bl = 0, m_gl = 0, m_lc = 0;
    bit m_bp = 0, m_gp = 0;

    always #4 clk = ~clk;

    lnk_rx_sync u_dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int run_len(input int len, input bit pol, input bit good);
        return (good == pol) ? ((len >= 65535) ? 65535 : len + 1) : 1;
    endfunction

    task automatic model_step();
        int  bn, gn, ln, ns;
        bit  bok, bbad, gok, gbad, lhit;
        bn   = run_len(m_bl, m_bp, blk_good_i);
        gn   = run_len(m_gl, m_gp, grp_good_i);
        ln   = (m_lc >= 65535) ? 65535 : m_lc + 1;
        bok  = blk_vld_i &&  blk_good_i && bn >= int'(blk_ok_thr_i);
        bbad = blk_vld_i && !blk_good_i && bn >= int'(blk_bad_thr_i);
        gok  = grp_vld_i &&  grp_good_i && gn >= int'(grp_ok_thr_i);
        gbad = grp_vld_i && !grp_good_i && gn >= int'(grp_bad_thr_i);
        lhit = lcv_i && ln >= int'(lcv_thr_i);
        ns = m_st;
        if (!link_en_i) ns = 0;
        else if (m_st == 0) begin if (bok) ns = 1; end
        else if (m_st == 1) begin if (bbad) ns = 0; else if (gok) ns = 3; end
        else begin
            if ((lcv_unsync_en_i && lhit) || bbad) ns = 0;
            else if (gbad) ns = 1;
        end
        if (!link_en_i || ns != m_st) begin
            m_bl = 0; m_bp = 0; m_gl = 0; m_gp = 0; m_lc = 0;
        end else begin
            if (blk_vld_i) begin m_bl = bn; m_bp = blk_good_i; end
            if (grp_vld_i) begin m_gl = gn; m_gp = grp_good_i; end
            if (lcv_i) m_lc = ln;
        end
        m_st = ns;
    endtask

    // Inputs are set at a falling edge; outputs compared before and after the edge.
    task automatic cyc(input string req);
        #1;
        chk({req, " err_o"}, int'(err_o), int'(err_i && (!err_supp_en_i || m_st == 3)));
        chk({req, " align_dis_o"}, int'(align_dis_o), int'(auto_align_en_i && m_st == 3));
        model_step();
        @(negedge clk);
        chk({req, " state"}, int'(state_o), m_st);
    endtask

    task automatic ev(input bit bv, input bit bg, input bit gv, input bit gg, input bit lv, input string req);
        blk_vld_i = bv; blk_good_i = bg; grp_vld_i = gv; grp_good_i = gg; lcv_i = lv;
        cyc(req);
        blk_vld_i = 0; grp_vld_i = 0; lcv_i = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(negedge clk);
        chk("R1 reset state", int'(state_o), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after reset", int'(state_o), 0);
        link_en_i = 1;

        // R7: invalid blocks ignored while unlocked
        blk_bad_thr_i = 1;
        for (int i = 0; i < 5; i++) ev(1, 0, 0, 0, 0, "R7");
        chk("R7 stays unlocked", int'(state_o), 0);

        // R2 with a restart (R6)
        blk_ok_thr_i = 3; blk_bad_thr_i = 4;
        ev(1, 1, 0, 0, 0, "R2"); ev(1, 1, 0, 0, 0, "R2");
        ev(1, 0, 0, 0, 0, "R6");
        ev(1, 1, 0, 0, 0, "R6"); ev(1, 1, 0, 0, 0, "R6");
        chk("R6 restart holds state 0", int'(state_o), 0);
        ev(1, 1, 0, 0, 0, "R2");
        chk("R2 block lock", int'(state_o), 1);

        // R3, R8, R9
        err_supp_en_i = 1; auto_align_en_i = 1; err_i = 1;
        grp_ok_thr_i = 2; grp_bad_thr_i = 2;
        ev(0, 0, 1, 1, 0, "R8 masked in 1");
        chk("R8 err masked", int'(err_o), 0);
        ev(0, 0, 1, 1, 0, "R3");
        chk("R3 frame lock", int'(state_o), 3);
        chk("R9 align request", int'(align_dis_o), 1);
        chk("R8 err passed in 3", int'(err_o), 1);
        err_i = 0;

        // R4
        ev(0, 0, 1, 0, 0, "R4"); ev(0, 0, 1, 0, 0, "R4");
        chk("R4 back to block lock", int'(state_o), 1);
        ev(0, 0, 1, 1, 0, "R6 counts cleared"); // one good group: not yet locked
        chk("R6 cleared run", int'(state_o), 1);
        ev(0, 0, 1, 1, 0, "R3");
        chk("R3 relock", int'(state_o), 3);

        // R10: disabled first, then enabled
        lcv_thr_i = 2;
        ev(0, 0, 0, 0, 1, "R10"); ev(0, 0, 0, 0, 1, "R10"); ev(0, 0, 0, 0, 1, "R10");
        chk("R10 disabled no effect", int'(state_o), 3);
        lcv_unsync_en_i = 1;
        ev(0, 0, 0, 0, 1, "R10");
        chk("R10 unlock", int'(state_o), 0);
        lcv_unsync_en_i = 0;

        // R5 priority in block lock
        blk_ok_thr_i = 1; blk_bad_thr_i = 1; grp_ok_thr_i = 1;
        ev(1, 1, 0, 0, 0, "R2");
        chk("R2 lock again", int'(state_o), 1);
        ev(1, 0, 1, 1, 0, "R5");
        chk("R5 unlock wins", int'(state_o), 0);

        // R1 link disable, R2 zero threshold
        blk_ok_thr_i = 0;
        ev(1, 1, 0, 0, 0, "R2 zero thr");
        chk("R2 zero threshold", int'(state_o), 1);
        link_en_i = 0;
        ev(0, 0, 0, 0, 0, "R1");
        chk("R1 disabled", int'(state_o), 0);
        ev(1, 1, 0, 0, 0, "R1 held");
        chk("R1 held while disabled", int'(state_o), 0);
        link_en_i = 1;

        // Random segments (R2..R11)
        for (int s = 0; s < 40; s++) begin
            int pb, pg;
            blk_ok_thr_i  = 16'($urandom_range(0, 4));
            blk_bad_thr_i = 16'($urandom_range(1, 5));
            grp_ok_thr_i  = 16'($urandom_range(0, 4));
            grp_bad_thr_i = 16'($urandom_range(1, 4));
            lcv_thr_i     = 16'($urandom_range(1, 6));
            err_supp_en_i   = 1'($urandom_range(0, 1));
            auto_align_en_i = 1'($urandom_range(0, 1));
            lcv_unsync_en_i = 1'($urandom_range(0, 1));
            pb = $urandom_range(55, 95);
            pg = $urandom_range(50, 95);
            for (int c = 0; c < 80; c++) begin
                link_en_i = ($urandom_range(0, 199) != 0);
                err_i     = 1'($urandom_range(0, 1));
                ev(1'($urandom_range(0, 1)), ($urandom_range(0, 99) < pb),
                   1'($urandom_range(0, 1)), ($urandom_range(0, 99) < pg),
                   ($urandom_range(0, 9) == 0), "R11 random");
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule